// File: doc/BRIEF.md
# EEPROM Access Controller with CPU Stall

This block connects a small processor's register strobes to an on-chip byte-wide EEPROM array. Software loads a 9-bit address register and an 8-bit data register, then either strobes a read, which copies the addressed byte into the data register on the next clock and holds a halt line high so the processor pipeline waits a fixed number of cycles, or arms and launches a self-timed write. The write length is counted in ticks of a separate calibrated timebase (`tick_i`), not in processor clocks. While the write runs, a busy flag is raised; reads are refused and the address register is frozen until the flag drops by itself.

The write engine is reset only by loss of supply, so a processor reset in the middle of a write leaves the write running to completion. If supply drops during a write, the engine abandons it without touching the array and a sticky error bit is raised. The array is a simple behavioural memory whose depth is a parameter; the 9-bit address wraps modulo that depth.

Top module: `ee_ctrl`

## Requirements
- R1: After `rst_ni` is released with supply good, `addr_o` and `data_o` read 0 and `busy_o`, `halt_o` and `err_o` are low.
- R2: A `rd_go_i` pulse, taken while `busy_o` and `halt_o` are both low, loads the byte stored at the current address into `data_o` at the next clock edge.
- R3: An accepted read raises `halt_o` for exactly HALT_CYC (default 4) consecutive cycles starting after that edge; a `rd_go_i` pulse while `halt_o` is high is ignored and leaves `data_o` unchanged.
- R4: While `busy_o` is high, `rd_go_i` neither changes `data_o` nor raises `halt_o`, and `addr_we_i` leaves `addr_o` unchanged.
- R5: A `wr_go_i` pulse starts a write only if `arm_i` was pulsed 1 to ARM_WIN (default 4) cycles before it; otherwise `busy_o` stays low and the array is not modified.
- R6: An accepted write raises `busy_o` at the next edge with the address and data register values captured; `busy_o` falls on the edge that sees the WR_TICKS-th (default 5) `tick_i` pulse, and the array holds the new byte from then on. Clock cycles without a tick do not advance the write.
- R7: Pulsing `rst_ni` low during a write clears the processor-side registers but the write keeps running: `busy_o` stays high and the byte is stored after the remaining ticks.
- R8: If `supply_ok_i` is low at an edge while a write is busy, the write is dropped, `busy_o` falls, `err_o` becomes 1 and stays 1 until `rst_ni`, and no array location changes.
- R9: The array index is the address modulo DEPTH (a power of two, default 256), so with the default depth the addresses 0x105 and 0x005 name the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous processor reset |
| supply_ok_i | input | 1 | Supply-good level, synchronous to clk_i; low resets the write engine |
| tick_i | input | 1 | One-cycle pulse from the calibrated write timebase |
| addr_we_i | input | 1 | Load address register |
| addr_i | input | 9 | New address register value |
| data_we_i | input | 1 | Load data register |
| data_i | input | 8 | New data register value |
| arm_i | input | 1 | Arm pulse opening the write-start window |
| wr_go_i | input | 1 | Write start request |
| rd_go_i | input | 1 | Read strobe |
| addr_o | output | 9 | Address register |
| data_o | output | 8 | Data register |
| busy_o | output | 1 | Write in progress |
| halt_o | output | 1 | Processor stall after a read |
| err_o | output | 1 | Sticky write-abort flag |

## Verification
Reads are tried on bytes written with alternating, all-ones-adjacent and sparse bit patterns at the low, middle and top of the index range, which separates a correct data path from a stuck or swapped bit and a wrong index. Write-start requests are placed exactly at the edge of the arming window and one cycle past it, and with no arm at all, which tells an off-by-one window from a correct one. Reads and address loads are aimed into a busy write and into an active halt, and a processor reset and a supply drop are injected mid-write, so that each interlock is told apart from the plain path by whether the data register, the address register, the halt line or the stored byte moves. Aliased addresses above the array depth distinguish modulo indexing from full-width decoding.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/ee_array.sv
module ee_array
  import ee_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  byte_t         wdata_i,
  input  logic [IW-1:0] raddr_i,
  output byte_t         rdata_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ee_wr_engine.sv
module ee_wr_engine
  import ee_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int WR_TICKS = 5,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(WR_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          supply_ok_i,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [IW-1:0] addr_i,
  input  byte_t         data_i,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [IW-1:0] mem_addr_o,
  output byte_t         mem_data_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] addr_q;
  byte_t         data_q;

  // Only supply loss resets the engine: a processor reset must not cut a write.
  always_ff @(posedge clk_i) begin
    if (!supply_ok_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WR_TICKS);
      addr_q <= addr_i;
      data_q <= data_i;
    end else if (busy_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o     = busy_q;
  assign mem_we_o   = busy_q && tick_i && supply_ok_i && (cnt_q == CW'(1));
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    (busy_q && !tick_i) |=> busy_q) else $error("busy dropped without tick"); // R6
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int WR_TICKS = 5,
  parameter int HALT_CYC = 4,
  parameter int ARM_WIN  = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int HW = $clog2(HALT_CYC + 1),
  localparam int AW = $clog2(ARM_WIN + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        supply_ok_i,
  input  logic        tick_i,
  input  logic        addr_we_i,
  input  logic [8:0]  addr_i,
  input  logic        data_we_i,
  input  logic [7:0]  data_i,
  input  logic        arm_i,
  input  logic        wr_go_i,
  input  logic        rd_go_i,
  output logic [8:0]  addr_o,
  output logic [7:0]  data_o,
  output logic        busy_o,
  output logic        halt_o,
  output logic        err_o
);
  addr_t         addr_q;
  byte_t         data_q;
  logic [HW-1:0] halt_q;
  logic [AW-1:0] arm_q;
  logic          err_q;

  logic          busy;
  logic          rd_ok, wr_ok;
  byte_t         rd_data;
  logic          mem_we;
  logic [IW-1:0] mem_addr;
  byte_t         mem_data;

  assign rd_ok = rd_go_i && !busy && (halt_q == '0);
  assign wr_ok = wr_go_i && !busy && (arm_q != '0) && supply_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      halt_q <= '0;
      arm_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (addr_we_i && !busy) addr_q <= addr_i;

      if (rd_ok)          data_q <= rd_data;
      else if (data_we_i) data_q <= data_i;

      if (rd_ok)              halt_q <= HW'(HALT_CYC);
      else if (halt_q != '0)  halt_q <= halt_q - 1'b1;

      if (wr_ok)             arm_q <= '0;
      else if (arm_i)        arm_q <= AW'(ARM_WIN);
      else if (arm_q != '0)  arm_q <= arm_q - 1'b1;

      if (busy && !supply_ok_i) err_q <= 1'b1;
    end
  end

  ee_wr_engine #(.DEPTH(DEPTH), .WR_TICKS(WR_TICKS)) u_eng (
    .clk_i      (clk_i),
    .supply_ok_i(supply_ok_i),
    .tick_i     (tick_i),
    .start_i    (wr_ok),
    .addr_i     (addr_q[IW-1:0]),
    .data_i     (data_q),
    .busy_o     (busy),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_data_o (mem_data)
  );

  ee_array #(.DEPTH(DEPTH)) u_arr (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_addr),
    .wdata_i(mem_data),
    .raddr_i(addr_q[IW-1:0]),
    .rdata_o(rd_data)
  );

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign busy_o = busy;
  assign halt_o = (halt_q != '0);
  assign err_o  = err_q;

  AST_RD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go_i && !busy_o && !halt_o) |=> (data_o == $past(rd_data))) else $error("read load"); // R2
  AST_HALT_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go_i && !busy_o && !halt_o) |=> halt_o) else $error("no halt"); // R3
  AST_BUSY_NO_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go_i && busy_o && !halt_o) |=> (!halt_o && $stable(data_o))) else $error("busy read"); // R4
  AST_ADDR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_o)) else $error("addr moved"); // R4
  AST_UNARMED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go_i && !busy_o && arm_q == '0) |=> !busy_o) else $error("unarmed write"); // R5
  AST_ABORT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !supply_ok_i) |=> (err_o && !busy_o)) else $error("abort"); // R8
endmodule

// File: tb/ee_ctrl_bench.sv
module ee_ctrl_bench;
  localparam int WR_TICKS = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       addr_we_i = 1'b0;
  logic [8:0] addr_i = '0;
  logic       data_we_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       arm_i = 1'b0;
  logic       wr_go_i = 1'b0;
  logic       rd_go_i = 1'b0;
  logic [8:0] addr_o;
  logic [7:0] data_o;
  logic       busy_o, halt_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ee_ctrl u_ee_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i), .tick_i(tick_i),
    .addr_we_i(addr_we_i), .addr_i(addr_i), .data_we_i(data_we_i), .data_i(data_i),
    .arm_i(arm_i), .wr_go_i(wr_go_i), .rd_go_i(rd_go_i),
    .addr_o(addr_o), .data_o(data_o), .busy_o(busy_o), .halt_o(halt_o), .err_o(err_o)
  );

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_addr(logic [8:0] a);
    addr_we_i = 1'b1; addr_i = a; cyc(); addr_we_i = 1'b0;
  endtask

  task automatic set_data(logic [7:0] d);
    data_we_i = 1'b1; data_i = d; cyc(); data_we_i = 1'b0;
  endtask

  task automatic give_tick();
    tick_i = 1'b1; cyc(); tick_i = 1'b0; cyc();
  endtask

  // arm, then request after 'gap' idle cycles
  task automatic start_write(logic [8:0] a, logic [7:0] d, int gap = 0);
    set_addr(a); set_data(d);
    arm_i = 1'b1; cyc(); arm_i = 1'b0;
    cyc(gap);
    wr_go_i = 1'b1; cyc(); wr_go_i = 1'b0;
  endtask

  task automatic full_write(logic [8:0] a, logic [7:0] d);
    start_write(a, d);
    for (int i = 0; i < WR_TICKS; i++) give_tick();
  endtask

  task automatic read_at(logic [8:0] a);
    set_addr(a);
    rd_go_i = 1'b1; cyc(); rd_go_i = 1'b0;
    cyc(HALT_WAIT);
  endtask
  localparam int HALT_WAIT = 5;

  task automatic t_reset();
    check("R1 addr", 16'(addr_o), 16'h0);
    check("R1 data", 16'(data_o), 16'h0);
    check("R1 flags busy/halt/err", {13'b0, busy_o, halt_o, err_o}, 16'h0);
  endtask

  task automatic t_write_read();
    int highs;
    start_write(9'h012, 8'h5A);
    check("R6 busy after start", 16'(busy_o), 16'h1);
    for (int i = 0; i < WR_TICKS - 1; i++) give_tick();
    cyc(3);
    check("R6 busy before last tick", 16'(busy_o), 16'h1);
    give_tick();
    check("R6 busy after last tick", 16'(busy_o), 16'h0);
    set_addr(9'h012);
    rd_go_i = 1'b1; cyc(); rd_go_i = 1'b0;
    check("R2 read 0x12", 16'(data_o), 16'h5A);
    highs = 0;
    for (int i = 0; i < 7; i++) begin
      if (halt_o) highs++;
      cyc();
    end
    check("R3 halt length", 16'(highs), 16'h4);
    full_write(9'h000, 8'hA5);
    full_write(9'h0FF, 8'h3C);
    full_write(9'h080, 8'h01);
    read_at(9'h000); check("R2 read 0x00", 16'(data_o), 16'hA5);
    read_at(9'h0FF); check("R2 read 0xFF", 16'(data_o), 16'h3C);
    read_at(9'h080); check("R2 read 0x80", 16'(data_o), 16'h01);
  endtask

  task automatic t_halt_ignore();
    set_addr(9'h000);
    rd_go_i = 1'b1; cyc(); rd_go_i = 1'b0;
    set_addr(9'h0FF);
    rd_go_i = 1'b1; cyc(); rd_go_i = 1'b0;
    check("R3 read during halt ignored", 16'(data_o), 16'hA5);
    cyc(); check("R3 halt still high", 16'(halt_o), 16'h1);
    cyc(); check("R3 halt ended", 16'(halt_o), 16'h0);
  endtask

  task automatic t_busy_interlock();
    start_write(9'h020, 8'h77);
    set_addr(9'h055);
    check("R4 addr frozen", 16'(addr_o), 16'h020);
    rd_go_i = 1'b1; cyc(); rd_go_i = 1'b0;
    check("R4 busy read data", 16'(data_o), 16'h77);
    check("R4 busy read no halt", 16'(halt_o), 16'h0);
    for (int i = 0; i < WR_TICKS; i++) give_tick();
    read_at(9'h020); check("R6 stored 0x20", 16'(data_o), 16'h77);
  endtask

  task automatic t_arm();
    full_write(9'h040, 8'h10);
    start_write(9'h040, 8'hEE, 3);
    check("R5 gap of 3 accepted", 16'(busy_o), 16'h1);
    for (int i = 0; i < WR_TICKS; i++) give_tick();
    start_write(9'h041, 8'hDD, 4);
    check("R5 gap of 4 dropped", 16'(busy_o), 16'h0);
    set_addr(9'h041); set_data(8'hDD);
    wr_go_i = 1'b1; cyc(); wr_go_i = 1'b0;
    check("R5 no arm dropped", 16'(busy_o), 16'h0);
    for (int i = 0; i < WR_TICKS; i++) give_tick();
    full_write(9'h041, 8'h42);
    read_at(9'h040); check("R5 armed value", 16'(data_o), 16'hEE);
    read_at(9'h041); check("R5 dropped left value", 16'(data_o), 16'h42);
  endtask

  task automatic t_reset_survive();
    start_write(9'h060, 8'hB7);
    give_tick(); give_tick();
    rst_ni = 1'b0; cyc(2); rst_ni = 1'b1; cyc();
    check("R7 busy across reset", 16'(busy_o), 16'h1);
    check("R7 addr cleared", 16'(addr_o), 16'h0);
    for (int i = 0; i < WR_TICKS - 2; i++) give_tick();
    check("R7 done", 16'(busy_o), 16'h0);
    read_at(9'h060); check("R7 stored", 16'(data_o), 16'hB7);
  endtask

  task automatic t_brownout();
    full_write(9'h030, 8'h11);
    full_write(9'h031, 8'h22);
    start_write(9'h030, 8'h99);
    give_tick(); give_tick();
    supply_ok_i = 1'b0; cyc(); supply_ok_i = 1'b1;
    check("R8 busy dropped", 16'(busy_o), 16'h0);
    check("R8 err set", 16'(err_o), 16'h1);
    for (int i = 0; i < WR_TICKS; i++) give_tick();
    check("R8 err sticky", 16'(err_o), 16'h1);
    read_at(9'h030); check("R8 target kept", 16'(data_o), 16'h11);
    read_at(9'h031); check("R8 neighbour kept", 16'(data_o), 16'h22);
    rst_ni = 1'b0; cyc(); rst_ni = 1'b1; cyc();
    check("R8 err cleared by reset", 16'(err_o), 16'h0);
  endtask

  task automatic t_wrap();
    full_write(9'h105, 8'hC3);
    read_at(9'h005); check("R9 alias 0x105->0x005", 16'(data_o), 16'hC3);
    full_write(9'h006, 8'h4E);
    read_at(9'h106); check("R9 alias 0x106->0x006", 16'(data_o), 16'h4E);
  endtask

  initial begin
    cyc(2);
    supply_ok_i = 1'b1;
    cyc(2);
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_write_read();
    t_halt_ignore();
    t_busy_interlock();
    t_arm();
    t_reset_survive();
    t_brownout();
    t_wrap();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end
endmodule